// File: doc/BRIEF.md
# Accumulator Overflow Saturation Unit

This block clamps a wide accumulator after a run of multiply-accumulate steps has left it outside the signed 32-bit range. The caller gives the current 40-bit accumulator value, the overflow flag that an earlier arithmetic step recorded for that accumulator, and a one-cycle saturate command. On the clock edge that captures the command, the block registers a replacement value. If the flag is clear, the replacement is the accumulator unchanged. If the flag is set, the replacement is the most positive or the most negative 32-bit number, sign-extended to the full width. The direction comes from the accumulator's top bit.

Each command acts once. Nothing is remembered between commands, so a later command with a clear flag passes its value through untouched. The block has no status outputs and never alters the overflow flag. Between commands, the registered accumulator keeps its value and the inputs have no effect. A value that has wrapped past its top bit is saturated in whichever direction that top bit indicates, and no attempt is made to detect the wrap.

Top module: `acc_sat_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_out` becomes 0 and `wb_valid` becomes 0.
- R2: A command (`sat_req`=1) with `ovf_flag`=0 makes `acc_out` equal to `acc_in` one cycle later, whatever bit 39 holds.
- R3: A command with `ovf_flag`=1 and `acc_in[39]`=0 makes `acc_out` equal to 0x00_7FFF_FFFF one cycle later.
- R4: A command with `ovf_flag`=1 and `acc_in[39]`=1 makes `acc_out` equal to 0xFF_8000_0000 one cycle later.
- R5: In a cycle with `sat_req`=0, `acc_out` keeps its previous value, and `acc_in` and `ovf_flag` are ignored.
- R6: Saturation is not sticky. A command that follows a clamping command, and that has `ovf_flag`=0, passes its value through unchanged.
- R7: `wb_valid` is 1 exactly in the cycle after a command and is 0 otherwise.
- R8: After a clamp, bits 39 down to 31 of `acc_out` are either all 0 or all 1.
- R9: The clamp direction depends only on bit 39. For example, 0x7F_FFFF_FFFF with the flag set goes positive, and 0x80_0000_0001 goes negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sat_req | input | 1 | Saturate command, one cycle |
| ovf_flag | input | 1 | Recorded overflow flag of the accumulator |
| acc_in | input | 40 | Current accumulator value |
| acc_out | output | 40 | Registered replacement accumulator value |
| wb_valid | output | 1 | High in the cycle after a command is captured |

## Verification
A wrongly decoded action appears on `acc_out` in the cycle right after the command. It shows either as a clamp where the value should have passed through, or as the wrong clamp polarity. A register that fails to hold shows up as a changed `acc_out` on the first idle cycle. Any leftover state between commands would corrupt the very next command that has the flag clear. Random stimulus is compared with a bench model on every cycle, so any such fault is caught within one cycle of when it occurs.

// File: rtl/acc_sat_pkg.sv
package acc_sat_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_POS  = 2'd1,
    ACT_NEG  = 2'd2
  } sat_act_e;
endpackage

// File: rtl/acc_sat_decide.sv
module acc_sat_decide
  import acc_sat_pkg::*;
(
  input  logic     ovf_flag,
  input  logic     sign_bit,
  output sat_act_e act
);
  always_comb begin
    if (!ovf_flag)     act = ACT_KEEP;
    else if (sign_bit) act = ACT_NEG;
    else               act = ACT_POS;
  end

  // R9: when flagged, direction follows the top bit only
  always_comb begin
    if (ovf_flag) begin
      p_dir_r9: assert (act != ACT_KEEP);
    end
  end
endmodule

// File: rtl/acc_sat_clamp.sv
module acc_sat_clamp #(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 32
) (
  output logic [ACC_W-1:0] pos_val,
  output logic [ACC_W-1:0] neg_val
);
  localparam int SIGN_POS = WORD_W - 1;

  for (genvar i = 0; i < ACC_W; i++) begin : g_bit
    if (i < SIGN_POS) begin : g_mag
      assign pos_val[i] = 1'b1;
      assign neg_val[i] = 1'b0;
    end else begin : g_ext
      assign pos_val[i] = 1'b0;
      assign neg_val[i] = 1'b1;
    end
  end
endmodule

// File: rtl/acc_sat_wb.sv
module acc_sat_wb
  import acc_sat_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sat_req,
  input  sat_act_e         act,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [ACC_W-1:0] pos_val,
  input  logic [ACC_W-1:0] neg_val,
  output logic [ACC_W-1:0] acc_q,
  output logic             wb_q
);
  logic [ACC_W-1:0] next_val;

  always_comb begin
    unique case (act)
      ACT_POS: next_val = pos_val;
      ACT_NEG: next_val = neg_val;
      default: next_val = acc_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      wb_q  <= 1'b0;
    end else begin
      wb_q <= sat_req;
      if (sat_req) acc_q <= next_val;
    end
  end

  // R5: idle cycles leave the register alone
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !sat_req |=> $stable(acc_q));
  // R7: write-back marker follows the command by one cycle
  p_valid_r7: assert property (@(posedge clk) disable iff (rst)
    sat_req |=> wb_q);
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !sat_req |=> !wb_q);
endmodule

// File: rtl/acc_sat_unit.sv
module acc_sat_unit
  import acc_sat_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sat_req,
  input  logic             ovf_flag,
  input  logic [ACC_W-1:0] acc_in,
  output logic [ACC_W-1:0] acc_out,
  output logic             wb_valid
);
  localparam int EXT_W = ACC_W - WORD_W;
  localparam logic [ACC_W-1:0] MAX_POS = {{(EXT_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MAX_NEG = {{(EXT_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

  sat_act_e         act;
  logic [ACC_W-1:0] pos_val;
  logic [ACC_W-1:0] neg_val;

  acc_sat_decide u_decide (
    .ovf_flag (ovf_flag),
    .sign_bit (acc_in[ACC_W-1]),
    .act      (act)
  );

  acc_sat_clamp #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_clamp (
    .pos_val (pos_val),
    .neg_val (neg_val)
  );

  acc_sat_wb #(.ACC_W(ACC_W)) u_wb (
    .clk     (clk),
    .rst     (rst),
    .sat_req (sat_req),
    .act     (act),
    .acc_in  (acc_in),
    .pos_val (pos_val),
    .neg_val (neg_val),
    .acc_q   (acc_out),
    .wb_q    (wb_valid)
  );

  // R2: flag clear passes the value through
  p_keep_r2: assert property (@(posedge clk) disable iff (rst)
    sat_req && !ovf_flag |=> acc_out == $past(acc_in));
  // R3: positive clamp
  p_pos_r3: assert property (@(posedge clk) disable iff (rst)
    sat_req && ovf_flag && !acc_in[ACC_W-1] |=> acc_out == MAX_POS);
  // R4: negative clamp
  p_neg_r4: assert property (@(posedge clk) disable iff (rst)
    sat_req && ovf_flag && acc_in[ACC_W-1] |=> acc_out == MAX_NEG);
  // R8: clamped result has a consistent extension
  p_ext_r8: assert property (@(posedge clk) disable iff (rst)
    sat_req && ovf_flag |=>
      (&acc_out[ACC_W-1:WORD_W-1]) || !(|acc_out[ACC_W-1:WORD_W-1]));
endmodule

// File: tb/acc_sat_unit_test.sv
module acc_sat_unit_test;
  localparam logic [39:0] POS = 40'h00_7FFF_FFFF;
  localparam logic [39:0] NEG = 40'hFF_8000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sat_req = 1'b0;
  logic        ovf_flag = 1'b0;
  logic [39:0] acc_in = '0;
  logic [39:0] acc_out;
  logic        wb_valid;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [39:0] model = '0;

  always #10 clk = ~clk;

  acc_sat_unit uut (
    .clk(clk), .rst(rst), .sat_req(sat_req), .ovf_flag(ovf_flag),
    .acc_in(acc_in), .acc_out(acc_out), .wb_valid(wb_valid)
  );

  function automatic logic [39:0] sat_ref(input logic f, input logic [39:0] v);
    if (!f) return v;
    return v[39] ? NEG : POS;
  endfunction

  task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input string tag, input bit req, input bit f, input logic [39:0] v);
    sat_req = req; ovf_flag = f; acc_in = v;
    @(posedge clk);
    @(negedge clk);
    if (req) model = sat_ref(f, v);
    check(tag, acc_out, model);
    check("R7 wb_valid", {39'd0, wb_valid}, {39'd0, req});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [39:0] v;
    logic [31:0] lo;
    logic [31:0] hi;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 acc_out", acc_out, '0);
    check("R1 wb_valid", {39'd0, wb_valid}, '0);
    rst = 1'b0;
    step("R2 keep pos", 1, 0, 40'h12_3456_789A);
    step("R2 keep neg", 1, 0, 40'hF0_0000_1234);
    step("R5 hold", 0, 1, 40'h00_0000_0001);
    step("R3 clamp pos", 1, 1, 40'h05_0000_0000);
    check("R8 ext pos", {31'd0, acc_out[39:31]}, '0);
    step("R6 no sticky", 1, 0, 40'h80_0000_0000);
    step("R4 clamp neg", 1, 1, 40'hC0_0000_0000);
    check("R8 ext neg", {31'd0, acc_out[39:31]}, {31'd0, 9'h1FF});
    step("R5 hold idle", 0, 0, 40'hAA_AAAA_AAAA);
    step("R9 wrap pos", 1, 1, 40'h7F_FFFF_FFFF);
    step("R9 wrap neg", 1, 1, 40'h80_0000_0001);
    for (int i = 0; i < 400; i++) begin
      lo = $urandom();
      hi = $urandom();
      v = {hi[7:0], lo};
      step(hi[9] ? "R3/R4 random" : "R2 random", hi[8] | hi[10], hi[9], v);
    end
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 re-reset", acc_out, '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule